// File: doc/BRIEF.md
# Indexed Colour Palette with Panel Formatter

This block sits between the pixel fetch path and the panel interface of a display controller. It holds a 256-entry colour palette. Each entry is a 16-bit word with three 5-bit colour fields and one shared intensity bit. A host loads entries through a simple write port. The pixel stream presents an 8-bit index with a valid strobe. One clock later the block returns the matching entry, formatted for the panel type that was selected when the index arrived.

Three output formats are supported. For TFT panels the full 5-bit colours and the intensity bit are packed onto a 24-bit panel bus, and the filler bits are forced to zero. For the two STN formats (monochrome gray and colour) the colours are cut to their four most significant bits. They are presented on a separate 12-bit port that feeds a later dithering stage, and the panel bus stays at zero. The format code is captured together with the index, so a format change only affects pixels presented after it.

Top module: `pal_fmt_top`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released, `out_valid` is 0 and both `panel_data` and `stn_lanes` are zero, whatever `pix_valid` does.
- R2: `out_valid` equals the value `pix_valid` had at the previous rising clock edge, so the latency is exactly one cycle and back-to-back indices stream without gaps.
- R3: A host write with `wr_en` high stores `wr_data[15:0]` at entry `wr_addr`. The entry layout is bit 15 intensity, bits 14:10 blue, bits 9:5 green and bits 4:0 red. `wr_data[31:16]` has no effect on the stored entry.
- R4: In TFT mode (mode code 2), `panel_data[23:19]` carries blue, `panel_data[15:11]` carries green and `panel_data[7:3]` carries red, all 5 bits wide.
- R5: In TFT mode, the entry's intensity bit appears on `panel_data[18]`, `panel_data[10]` and `panel_data[2]`.
- R6: In TFT mode, `panel_data[17:16]`, `panel_data[9:8]` and `panel_data[1:0]` are 0, and `stn_lanes` is all zero.
- R7: In STN colour mode (mode code 1), `stn_lanes[11:8]` is blue[4:1], `stn_lanes[7:4]` is green[4:1] and `stn_lanes[3:0]` is red[4:1]. `panel_data` is zero.
- R8: In STN monochrome mode (mode code 0), `stn_lanes[3:0]` is red[4:1], giving 16 gray levels. `stn_lanes[11:4]` and `panel_data` are zero.
- R9: When a write and a lookup hit the same entry in the same cycle, the lookup returns the entry's previous contents. A later lookup returns the new contents.
- R10: Whenever `out_valid` is 0, `panel_data` and `stn_lanes` are zero.
- R11: Mode code 3 is reserved. A lookup captured with it gives `out_valid` 1 with `panel_data` and `stn_lanes` both zero.
- R12: The format applied to a result is the `mode` value sampled with its index. A change of `mode` after that edge does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Palette entry to write |
| wr_data | input | 32 | Write data; only bits 15:0 are stored |
| mode | input | 2 | Format code: 0 STN mono, 1 STN colour, 2 TFT, 3 reserved |
| pix_valid | input | 1 | Pixel index valid |
| pix_index | input | 8 | Pixel palette index |
| out_valid | output | 1 | Formatted result valid |
| panel_data | output | 24 | TFT panel data bus |
| stn_lanes | output | 12 | 4-bit STN colour/gray values for the dithering stage |

## Verification
The hardest case to reach from the ports is the same-cycle collision between a host write and a lookup of the same entry. Only there does the ordering of the palette read against the write show at the outputs. The stimulus loads a known entry, then in one cycle drives a write of different contents to that index together with a lookup of it. It expects the old word. A second lookup then confirms the new word. The mode-capture rule is reached in a similar way: the mode input is changed in the cycle after a lookup is accepted, while its result is still on the outputs.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int IDX_W     = 8;
    localparam int DEPTH     = 1 << IDX_W;
    localparam int COL_W     = 5;
    localparam int ENTRY_W   = 3 * COL_W + 1;
    localparam int HOST_W    = 32;
    localparam int LANE_W    = 8;
    localparam int PANEL_W   = 3 * LANE_W;
    localparam int STN_W     = COL_W - 1;
    localparam int STN_BUS_W = 3 * STN_W;

    typedef enum logic [1:0] {
        FMT_STN_MONO  = 2'd0,
        FMT_STN_COLOR = 2'd1,
        FMT_TFT       = 2'd2,
        FMT_RESERVED  = 2'd3
    } fmt_e;

    typedef struct packed {
        logic             inten;
        logic [COL_W-1:0] blu;
        logic [COL_W-1:0] grn;
        logic [COL_W-1:0] red;
    } pal_entry_t;

endpackage

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int P_IDX_W   = IDX_W,
    parameter int P_ENTRY_W = ENTRY_W
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [P_IDX_W-1:0]   waddr,
    input  logic [P_ENTRY_W-1:0] wdata,
    input  logic                 re,
    input  logic [P_IDX_W-1:0]   raddr,
    output logic [P_ENTRY_W-1:0] rdata
);

    localparam int P_DEPTH = 1 << P_IDX_W;

    logic [P_ENTRY_W-1:0] mem_q [P_DEPTH];

    // Write and read share one edge; the read sees the pre-write word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem_q[raddr];
        end
    end

endmodule

// File: rtl/pal_packer.sv
module pal_packer
    import pal_pkg::*;
(
    input  pal_entry_t           entry,
    input  fmt_e                 fmt,
    input  logic                 valid,
    output logic [PANEL_W-1:0]   panel,
    output logic [STN_BUS_W-1:0] stn
);

    localparam int NLANE = 3;
    localparam int PAD_W = LANE_W - COL_W - 1;

    logic [COL_W-1:0]  lane_col [NLANE];
    logic [LANE_W-1:0] tft_lane [NLANE];
    logic [STN_W-1:0]  stn_lane [NLANE];
    logic [PANEL_W-1:0]   tft_bus;
    logic [STN_BUS_W-1:0] color_bus;
    logic [STN_BUS_W-1:0] mono_bus;

    // lane 0 red, lane 1 green, lane 2 blue
    assign lane_col[0] = entry.red;
    assign lane_col[1] = entry.grn;
    assign lane_col[2] = entry.blu;

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        assign tft_lane[k] = {lane_col[k], entry.inten, {PAD_W{1'b0}}};
        assign stn_lane[k] = lane_col[k][COL_W-1:1];
        assign tft_bus[k*LANE_W +: LANE_W]  = tft_lane[k];
        assign color_bus[k*STN_W +: STN_W]  = stn_lane[k];
    end

    assign mono_bus = {{(STN_BUS_W-STN_W){1'b0}}, stn_lane[0]};

    always_comb begin
        panel = '0;
        stn   = '0;
        if (valid) begin
            unique case (fmt)
                FMT_STN_MONO:  stn   = mono_bus;
                FMT_STN_COLOR: stn   = color_bus;
                FMT_TFT:       panel = tft_bus;
                FMT_RESERVED:  begin
                    panel = '0;
                    stn   = '0;
                end
                default:       begin
                    panel = '0;
                    stn   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pal_fmt_top.sv
module pal_fmt_top
    import pal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_addr,
    input  logic [HOST_W-1:0]    wr_data,
    input  logic [1:0]           mode,
    input  logic                 pix_valid,
    input  logic [IDX_W-1:0]     pix_index,
    output logic                 out_valid,
    output logic [PANEL_W-1:0]   panel_data,
    output logic [STN_BUS_W-1:0] stn_lanes
);

    logic [ENTRY_W-1:0] rd_word;
    logic               vld_q;
    fmt_e               fmt_q;
    pal_entry_t         ent;

    pal_store #(
        .P_IDX_W   (IDX_W),
        .P_ENTRY_W (ENTRY_W)
    ) i_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data[ENTRY_W-1:0]),
        .re    (pix_valid),
        .raddr (pix_index),
        .rdata (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            fmt_q <= FMT_STN_MONO;
        end else begin
            vld_q <= pix_valid;
            if (pix_valid) begin
                fmt_q <= fmt_e'(mode);
            end
        end
    end

    assign ent       = pal_entry_t'(rd_word);
    assign out_valid = vld_q;

    pal_packer i_pack (
        .entry (ent),
        .fmt   (fmt_q),
        .valid (vld_q),
        .panel (panel_data),
        .stn   (stn_lanes)
    );

endmodule

// File: rtl/pal_fmt_chk.sv
module pal_fmt_chk
    import pal_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pix_valid,
    input logic [1:0]           mode,
    input logic                 out_valid,
    input logic [PANEL_W-1:0]   panel_data,
    input logic [STN_BUS_W-1:0] stn_lanes
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pix_valid) && $past(rst_n)) |-> out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_valid));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (panel_data == '0 && stn_lanes == '0));

    a_r5_inten_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) == 2'd2) |->
            (panel_data[18] == panel_data[10] && panel_data[10] == panel_data[2]));

    a_r6_tft_gaps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) == 2'd2) |->
            (panel_data[17:16] == 2'b00 && panel_data[9:8] == 2'b00 &&
             panel_data[1:0] == 2'b00 && stn_lanes == '0));

    a_r7_color_no_panel: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) == 2'd1) |-> panel_data == '0);

    a_r8_mono_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) == 2'd0) |->
            (stn_lanes[11:4] == 8'd0 && panel_data == '0));

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) == 2'd3) |->
            (panel_data == '0 && stn_lanes == '0));

endmodule

bind pal_fmt_top pal_fmt_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .mode       (mode),
    .out_valid  (out_valid),
    .panel_data (panel_data),
    .stn_lanes  (stn_lanes)
);

// File: tb/test_pal_fmt_top.sv
module test_pal_fmt_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    // {mode[1:0], index[7:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd0, 8'd0},   {2'd0, 8'd2},   {2'd0, 8'd77},  {2'd1, 8'd0},
        {2'd1, 8'd1},   {2'd1, 8'd2},   {2'd1, 8'd130}, {2'd2, 8'd0},
        {2'd2, 8'd1},   {2'd2, 8'd2},   {2'd2, 8'd255}, {2'd2, 8'd93},
        {2'd1, 8'd255}, {2'd0, 8'd200}, {2'd3, 8'd0},   {2'd2, 8'd17}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  mode = '0;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_index = '0;
    logic        out_valid;
    logic [23:0] panel_data;
    logic [11:0] stn_lanes;

    logic [15:0] shadow [256];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_fmt_top i_pal_fmt_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .mode       (mode),
        .pix_valid  (pix_valid),
        .pix_index  (pix_index),
        .out_valid  (out_valid),
        .panel_data (panel_data),
        .stn_lanes  (stn_lanes)
    );

    function automatic logic [15:0] seed_entry(int i);
        logic [31:0] t;
        if (i == 0)   return 16'hFFFF;
        if (i == 1)   return 16'h8000;
        if (i == 2)   return 16'h7FFF;
        if (i == 255) return 16'h0000;
        t = i * 40503 + 4660;
        return t[15:0];
    endfunction

    function automatic logic [23:0] want_panel(logic [1:0] m, logic [15:0] e);
        if (m == 2'd2)
            return {e[14:10], e[15], 2'b00, e[9:5], e[15], 2'b00, e[4:0], e[15], 2'b00};
        return 24'h0;
    endfunction

    function automatic logic [11:0] want_stn(logic [1:0] m, logic [15:0] e);
        if (m == 2'd0) return {8'h00, e[4:1]};
        if (m == 2'd1) return {e[14:11], e[9:6], e[4:1]};
        return 12'h0;
    endfunction

    task automatic chk(string tag, logic [23:0] got, logic [23:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic chk_result(string tag, logic [1:0] m, logic [15:0] e);
        chk({tag, " valid"}, {23'd0, out_valid}, 24'd1);
        chk({tag, " panel"}, panel_data, want_panel(m, e));
        chk({tag, " stn"}, {12'd0, stn_lanes}, {12'd0, want_stn(m, e)});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs quiet even with pix_valid high
        pix_valid = 1'b1;
        mode = 2'd2;
        repeat (3) @(negedge clk);
        chk("R1 rst valid", {23'd0, out_valid}, 24'd0);
        chk("R1 rst panel", panel_data, 24'd0);
        chk("R1 rst stn", {12'd0, stn_lanes}, 24'd0);
        pix_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-rst valid", {23'd0, out_valid}, 24'd0);

        // R3: load palette with junk in the upper host half
        for (int i = 0; i < 256; i++) begin
            wr_en = 1'b1;
            wr_addr = 8'(i);
            shadow[i] = seed_entry(i);
            wr_data = {16'hDEAD ^ 16'(i * 3), shadow[i]};
            @(negedge clk);
        end
        wr_en = 1'b0;

        // table walk, back-to-back
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] m;
            logic [7:0] ix;
            string tg;
            m = VEC[v][9:8];
            ix = VEC[v][7:0];
            case (m)
                2'd0: tg = "R8";
                2'd1: tg = "R7";
                2'd2: tg = "R4";
                default: tg = "R11";
            endcase
            mode = m;
            pix_index = ix;
            pix_valid = 1'b1;
            @(negedge clk);
            chk_result({tg, " R3 R2"}, m, shadow[ix]);
            if (m == 2'd2) begin
                chk("R5 inten", {21'd0, panel_data[18], panel_data[10], panel_data[2]},
                    {21'd0, {3{shadow[ix][15]}}});
                chk("R6 gaps", {18'd0, panel_data[17:16], panel_data[9:8], panel_data[1:0]}, 24'd0);
            end
        end

        // R10: idle output is zero
        pix_valid = 1'b0;
        @(negedge clk);
        chk("R10 idle valid", {23'd0, out_valid}, 24'd0);
        chk("R10 idle panel", panel_data, 24'd0);
        chk("R10 idle stn", {12'd0, stn_lanes}, 24'd0);

        // R9: write and read of the same entry in one cycle
        mode = 2'd2;
        pix_index = 8'd5;
        pix_valid = 1'b1;
        wr_en = 1'b1;
        wr_addr = 8'd5;
        wr_data = {16'hFFFF, 16'h1357};
        @(negedge clk);
        wr_en = 1'b0;
        chk_result("R9 old", 2'd2, shadow[5]);
        shadow[5] = 16'h1357;
        @(negedge clk);
        chk_result("R9 new", 2'd2, shadow[5]);

        // R12: mode changes after capture
        pix_index = 8'd77;
        mode = 2'd2;
        pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        mode = 2'd0;
        #1;
        chk_result("R12 held", 2'd2, shadow[77]);
        @(negedge clk);

        // R1: reset in mid-stream clears outputs
        pix_valid = 1'b1;
        pix_index = 8'd0;
        mode = 2'd1;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 mid-rst valid", {23'd0, out_valid}, 24'd0);
        chk("R1 mid-rst stn", {12'd0, stn_lanes}, 24'd0);
        pix_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule